// File: doc/BRIEF.md
# Binned Hit Store with Linked-List Readout

This block collects hit words that arrive in arbitrary order and sorts them by a bin key. Any number of hits may land in the same bin. Each accepted hit goes into the next free slot of a shared store. The slot is then linked in front of the bin's previous newest hit, so every bin is a singly linked list whose head pointer sits in a small per-bin table. No data is moved or copied when a hit is filed.

A consumer asks for one bin at a time. The block then walks that bin's list and presents one hit per clock, newest first, while `ready` is low. The consumer can ask for the same bin again with a replay command, and the walk repeats without the bin being refilled. Each bin head is tagged with an event number, and a head only counts as live when its tag equals the current event number. Advancing the event therefore empties every bin in one clock, and the slot allocator restarts at zero.

Top module: `hash_sorter`

## Requirements
- R1: After reset, `ready` is 1, while `outValid`, `overflow` and `waitFull` are 0.
- R2: Each accepted push files its word under `pushKey`. One bin can hold any number of words, up to the store capacity of 2^IDX_W words summed over all bins.
- R3: A pop accepted on a bin holding n words gives n consecutive cycles of `outValid`=1, starting in the cycle after the request. The words come out newest first. `ready` is 0 during those cycles and 1 again in the cycle after the last word.
- R4: A pop on a bin that has received no push in the current event produces no `outValid`, and `ready` stays 1.
- R5: A replay request while idle walks the most recently popped bin again and gives the identical sequence. If that pop found the bin empty, or an event advance has happened since, a replay produces nothing.
- R6: Pop and replay requests made while a walk is running are ignored. Pushes made during a walk are stored, including pushes to the bin being walked, and they do not change the walk in progress.
- R7: `newEvent` empties every bin and the store from the next cycle on. It clears `overflow`, aborts any walk so that `ready`=1 and `outValid`=0 the next cycle, and overrides a push, pop or replay in the same cycle.
- R8: `waitFull` is 1 exactly when 2^IDX_W words are stored in the current event. A push made while it is 1 is dropped, and `overflow` then goes to 1 and stays there until the next `newEvent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushEn | input | 1 | Store `pushData` under `pushKey` |
| pushKey | input | KEY_W | Bin of the pushed word |
| pushData | input | DATA_W | Hit word to store |
| popEn | input | 1 | Start walking bin `popKey` |
| repopEn | input | 1 | Walk the last popped bin again |
| popKey | input | KEY_W | Bin to walk |
| newEvent | input | 1 | Advance event, logically empty all bins |
| ready | output | 1 | Idle; pop and replay are accepted |
| outValid | output | 1 | `outData` carries a hit of the walked bin |
| outData | output | DATA_W | Hit word being read out |
| waitFull | output | 1 | Store full; pushes would be dropped |
| overflow | output | 1 | A push was dropped in this event |

## Verification
A corrupted link pointer or end-of-list flag shows up at the ports during the next walk of the affected bin. The walk gives a wrong word, ends early, or runs on past the expected count, and this is visible within n+1 cycles of the pop. A stale event tag or allocator value shows up as a supposedly emptied bin still producing words, or as a wrong `waitFull`, on the first pop or push after the event advance. Each readout is compared word by word against a per-bin model rebuilt arithmetically in the bench.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {ST_IDLE, ST_WALK} hsState_t;

  typedef struct packed {
    logic push;      // write a hit and relink its bin
    logic popLoad;   // load walk pointer from the requested bin head
    logic repopLoad; // load walk pointer from the saved head
    logic step;      // follow the link of the current entry
    logic newEvt;    // advance event tag, reset allocator
  } hsStrobes_t;
endpackage

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int DATA_W = 28,
  parameter int IDX_W  = 8,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsStrobes_t        strobe,
  input  logic [KEY_W-1:0]  pushKey,
  input  logic [DATA_W-1:0] pushData,
  input  logic [KEY_W-1:0]  popKey,
  output logic              binLive,
  output logic              storeFull,
  output logic              atTail,
  output logic [DATA_W-1:0] outData
);
  localparam int BINS  = 1 << KEY_W;
  localparam int CAP   = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;

  logic [DATA_W-1:0] dataMem [CAP];
  logic [IDX_W-1:0]  nextMem [CAP];
  logic              tailMem [CAP];
  logic [IDX_W-1:0]  headMem [BINS];
  logic [EVT_W-1:0]  headEvt [BINS];

  logic [EVT_W-1:0] curEvt;
  logic [CNT_W-1:0] fillCnt;
  logic [IDX_W-1:0] walkPtr;
  logic [IDX_W-1:0] savedHead;

  logic [IDX_W-1:0] freeIdx;
  logic             pushBinLive;
  logic [EVT_W-1:0] evtInc;

  assign freeIdx     = fillCnt[IDX_W-1:0];
  assign pushBinLive = (headEvt[pushKey] == curEvt);
  assign evtInc      = curEvt + 1'b1;

  assign binLive   = (headEvt[popKey] == curEvt);
  assign storeFull = fillCnt[IDX_W];
  assign atTail    = tailMem[walkPtr];
  assign outData   = dataMem[walkPtr];

  // Entry storage: data, link to older entry, end-of-list marker
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      dataMem[freeIdx] <= pushData;
      nextMem[freeIdx] <= headMem[pushKey];
      tailMem[freeIdx] <= !pushBinLive;
      headMem[pushKey] <= freeIdx;
    end
  end

  // Bin event tags; zero never equals a live event number
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BINS; b++) headEvt[b] <= '0;
    end else if (strobe.push) begin
      headEvt[pushKey] <= curEvt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curEvt    <= EVT_W'(1);
      fillCnt   <= '0;
      walkPtr   <= '0;
      savedHead <= '0;
    end else begin
      if (strobe.newEvt) begin
        curEvt  <= (evtInc == '0) ? EVT_W'(1) : evtInc;
        fillCnt <= '0;
      end else if (strobe.push) begin
        fillCnt <= fillCnt + 1'b1;
      end
      if (strobe.popLoad) begin
        walkPtr   <= headMem[popKey];
        savedHead <= headMem[popKey];
      end else if (strobe.repopLoad) begin
        walkPtr <= savedHead;
      end else if (strobe.step) begin
        walkPtr <= nextMem[walkPtr];
      end
    end
  end
endmodule

// File: rtl/hs_control.sv
module hs_control
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushEn,
  input  logic       popEn,
  input  logic       repopEn,
  input  logic       newEvent,
  input  logic       binLive,
  input  logic       storeFull,
  input  logic       atTail,
  output hsStrobes_t strobe,
  output logic       walking,
  output logic       overflowFlag
);
  hsState_t state, stateNext;
  logic     replayOk;
  logic     idle;

  assign idle    = (state == ST_IDLE);
  assign walking = (state == ST_WALK);

  always_comb begin
    strobe           = '0;
    strobe.newEvt    = newEvent;
    strobe.push      = pushEn && !newEvent && !storeFull;
    strobe.popLoad   = idle && popEn && binLive && !newEvent;
    strobe.repopLoad = idle && !popEn && repopEn && replayOk && !newEvent;
    strobe.step      = walking && !atTail && !newEvent;
  end

  always_comb begin
    stateNext = state;
    if (newEvent)
      stateNext = ST_IDLE;
    else if (idle && (strobe.popLoad || strobe.repopLoad))
      stateNext = ST_WALK;
    else if (walking && atTail)
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      replayOk     <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (newEvent) begin
        replayOk     <= 1'b0;
        overflowFlag <= 1'b0;
      end else begin
        if (idle && popEn) replayOk <= binLive;
        if (pushEn && storeFull) overflowFlag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hash_sorter.sv
module hash_sorter
  import hs_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int DATA_W = 28,
  parameter int IDX_W  = 8,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [KEY_W-1:0]  pushKey,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  input  logic              repopEn,
  input  logic [KEY_W-1:0]  popKey,
  input  logic              newEvent,
  output logic              ready,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              waitFull,
  output logic              overflow
);
  hsStrobes_t strobe;
  logic binLive, storeFull, atTail, walking;

  hs_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .pushEn(pushEn), .popEn(popEn), .repopEn(repopEn), .newEvent(newEvent),
    .binLive(binLive), .storeFull(storeFull), .atTail(atTail),
    .strobe(strobe), .walking(walking), .overflowFlag(overflow)
  );

  hs_datapath #(.KEY_W(KEY_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .EVT_W(EVT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushKey(pushKey), .pushData(pushData), .popKey(popKey),
    .binLive(binLive), .storeFull(storeFull), .atTail(atTail), .outData(outData)
  );

  assign ready    = !walking;
  assign outValid = walking;
  assign waitFull = storeFull;
endmodule

// File: rtl/hash_sorter_checker.sv
module hash_sorter_checker (
  input logic clk,
  input logic rstN,
  input logic pushEn,
  input logic newEvent,
  input logic ready,
  input logic outValid,
  input logic waitFull,
  input logic overflow
);
  // R3: a walk and the ready flag never overlap
  a_r3_ready_excl: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !ready);

  // R7: event advance ends any walk on the next cycle
  a_r7_event_idles: assert property (@(posedge clk) disable iff (!rstN)
    newEvent |=> (ready && !outValid && !overflow && !waitFull));

  // R8: overflow holds until the next event advance
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !newEvent) |=> overflow);

  // R8: overflow only rises after a push against a full store
  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(pushEn && waitFull && !newEvent));

  // R8: a full store stays full within an event
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (waitFull && !newEvent) |=> waitFull);

  // R1: idle values right after reset release
  always @(posedge clk) begin
    if (rstN && $rose(rstN)) begin
      a_r1_reset_idle: assert (ready && !outValid && !overflow && !waitFull);
    end
  end
endmodule

bind hash_sorter hash_sorter_checker u_chk (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .newEvent(newEvent),
  .ready(ready), .outValid(outValid), .waitFull(waitFull), .overflow(overflow)
);

// File: tb/hash_sorter_test.sv
module hash_sorter_test;
  localparam int KW  = 3;
  localparam int DW  = 12;
  localparam int IW  = 4;
  localparam int EW  = 4;
  localparam int NB  = 1 << KW;
  localparam int CAP = 1 << IW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushEn = 1'b0, popEn = 1'b0, repopEn = 1'b0, newEvent = 1'b0;
  logic [KW-1:0] pushKey = '0, popKey = '0;
  logic [DW-1:0] pushData = '0;
  logic ready, outValid, waitFull, overflow;
  logic [DW-1:0] outData;

  always #5 clk = ~clk;

  hash_sorter #(.KEY_W(KW), .DATA_W(DW), .IDX_W(IW), .EVT_W(EW)) uut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushKey(pushKey), .pushData(pushData),
    .popEn(popEn), .repopEn(repopEn), .popKey(popKey), .newEvent(newEvent),
    .ready(ready), .outValid(outValid), .outData(outData),
    .waitFull(waitFull), .overflow(overflow)
  );

  int vectors = 0, fails = 0;
  bit finished = 1'b0;
  int modelCnt [NB];
  logic [DW-1:0] modelList [NB][CAP];
  int total = 0;
  bit expOvf = 1'b0;
  bit lastValid = 1'b0;
  int lastKey = 0;
  int evtIdx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] mkData(input int k, input int j);
    return DW'((evtIdx * 256 + k * 16 + j) & ((1 << DW) - 1));
  endfunction

  task automatic modelPush(input int k, input logic [DW-1:0] d);
    if (total < CAP) begin
      modelList[k][modelCnt[k]] = d;
      modelCnt[k]++;
      total++;
    end else begin
      expOvf = 1'b1;
    end
  endtask

  // R2 R8: one push, then check the full and overflow flags
  task automatic pushHit(input int k, input logic [DW-1:0] d);
    pushEn = 1'b1; pushKey = KW'(k); pushData = d;
    @(negedge clk);
    pushEn = 1'b0;
    modelPush(k, d);
    chk(waitFull == (total == CAP), "R8 waitFull", int'(waitFull), int'(total == CAP));
    chk(overflow == expOvf, "R8 overflow", int'(overflow), int'(expOvf));
  endtask

  // R3 R4 R5 R6: request a walk and compare every word
  task automatic walkCheck(input int k, input bit rep, input bit interfere);
    int kk, expN;
    if (rep) begin
      kk = lastKey;
      expN = lastValid ? modelCnt[lastKey] : 0;
      repopEn = 1'b1;
    end else begin
      kk = k;
      expN = modelCnt[k];
      lastKey = k;
      lastValid = (modelCnt[k] > 0);
      popEn = 1'b1;
      popKey = KW'(k);
    end
    @(negedge clk);
    popEn = 1'b0; repopEn = 1'b0;
    for (int i = 0; i < expN; i++) begin
      chk(outValid && !ready, rep ? "R5 replay valid" : "R3 walk valid",
          int'({outValid, ready}), 2);
      chk(outData == modelList[kk][expN-1-i], rep ? "R5 replay data" : "R3 walk data",
          int'(outData), int'(modelList[kk][expN-1-i]));
      if (interfere && i == 0) begin
        popEn = 1'b1; popKey = KW'((kk + 1) % NB);
        repopEn = 1'b1;
        pushEn = 1'b1; pushKey = KW'(kk); pushData = mkData(kk, 9);
      end
      @(negedge clk);
      if (interfere && i == 0) begin
        popEn = 1'b0; repopEn = 1'b0; pushEn = 1'b0;
        modelPush(kk, mkData(kk, 9));
      end
    end
    chk(!outValid && ready, expN == 0 ? "R4 empty bin idle" : "R3 walk end",
        int'({outValid, ready}), 1);
  endtask

  // R7: advance the event
  task automatic advanceEvent();
    newEvent = 1'b1;
    @(negedge clk);
    newEvent = 1'b0;
    for (int b = 0; b < NB; b++) modelCnt[b] = 0;
    total = 0; expOvf = 1'b0; lastValid = 1'b0; evtIdx++;
    chk(ready && !outValid && !overflow && !waitFull, "R7 event clear",
        int'({ready, outValid, overflow, waitFull}), 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) modelCnt[b] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(ready && !outValid && !overflow && !waitFull, "R1 reset state",
        int'({ready, outValid, overflow, waitFull}), 8);

    // R4: every bin empty at start
    for (int b = 0; b < NB; b++) walkCheck(b, 1'b0, 1'b0);
    // R5: replay after an empty pop yields nothing
    walkCheck(0, 1'b1, 1'b0);

    // R2: bin b receives b%4 hits, pushed round robin
    for (int j = 0; j < 3; j++)
      for (int b = 0; b < NB; b++)
        if (j < b % 4) pushHit(b, mkData(b, j));

    // R3 R5: pop then replay each bin
    for (int b = 0; b < NB; b++) begin
      walkCheck(b, 1'b0, 1'b0);
      walkCheck(b, 1'b1, 1'b0);
    end

    // R6: requests during a walk ignored, push during a walk kept
    walkCheck(3, 1'b0, 1'b1);
    walkCheck(3, 1'b0, 1'b0);
    walkCheck(0, 1'b1, 1'b0);

    // R7: abort a walk mid-way
    popEn = 1'b1; popKey = KW'(3);
    @(negedge clk);
    popEn = 1'b0;
    chk(outValid, "R7 walk started", int'(outValid), 1);
    advanceEvent();
    for (int b = 0; b < NB; b++) walkCheck(b, 1'b0, 1'b0);
    advanceEvent();
    walkCheck(0, 1'b1, 1'b0);

    // R8: fill the store into one bin, then overflow
    for (int j = 0; j < CAP + 2; j++) pushHit(5, mkData(5, j));
    walkCheck(5, 1'b0, 1'b0);
    walkCheck(2, 1'b0, 1'b0);

    // R7 R2: allocator restarts after the event advance
    advanceEvent();
    pushHit(2, mkData(2, 1));
    pushHit(2, mkData(2, 2));
    walkCheck(2, 1'b0, 1'b0);
    walkCheck(5, 1'b0, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule